// File: doc/BRIEF.md
# Initialization Rate Switch for a Cipher Core

This block paces a shift-register cipher core through its two phases. While the core is being initialized, its feedback loops are closed and have the longest combinational path. During that phase the block issues a clock-enable only once in every two or four fast-clock cycles. The core's cycle counter raises a run request when initialization is over. From then on the enable stays high on every cycle, so the core runs at the full rate for keystream generation.

The change of rate goes one way only. The run request is captured in a register before it reaches the enable select, so the change happens on a clean edge. The first full-rate cycle is never shorter than one fast period, and no extra enable pulse appears. The divide ratio is a configuration setting that is captured while reset is held. The divider is built as a chain of toggling stages: one stage gives a ratio of two, and two cascaded stages give a ratio of four.

Top module: `initclk_switch`

## Requirements
- R1: While rst_n is low at a rising edge, clk_en is low in the following cycle. After reset the block is in the slow phase with the divider at phase zero.
- R2: The divide setting is taken from div_sel only at rising edges where rst_n is low. The value 0 selects divide by 2 and the value 1 selects divide by 4. A change of div_sel while rst_n is high has no effect on clk_en.
- R3: With divide by 2, in the slow phase, clk_en is high exactly in the cycles after an odd number of rising edges since reset was released. The first pulse is in the second cycle.
- R4: With divide by 4, in the slow phase, clk_en is high exactly in the cycles after 3, 7, 11, ... rising edges since reset was released. Two high cycles are always separated by three low cycles.
- R5: When run_req is high at a rising edge with rst_n high, clk_en is high from the cycle after that edge. No enable gap or shortened pulse appears, whatever the divider phase was.
- R6: Once the fast phase is entered, clk_en stays high on every cycle until the next reset, even after run_req falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; every register of the block is clocked by it |
| rst_n | input | 1 | Synchronous active-low reset; also loads the divide setting |
| div_sel | input | SEL_W (1) | Divide setting: 0 for divide by 2, 1 for divide by 4 |
| run_req | input | 1 | Run request from the core's cycle counter; ends initialization |
| clk_en | output | 1 | Clock-enable for the cipher core |

## Verification
Four behaviours are checked by the bound checker on every cycle:
- the enable is low after a reset edge;
- a sampled run request produces an enable in the very next cycle;
- the fast phase never ends before a reset;
- the slow phase never yields two enables in a row.

Other behaviours can only be shown by the bench's scenarios, which compare every cycle against a behavioural edge-count model. These are:
- the exact pulse positions for each ratio;
- that the ratio is taken only during reset;
- that the switch is clean when the request arrives at every divider phase, including while reset is still held.

// File: rtl/initclk_pkg.sv
// Package initclk_pkg
// Shared types for the initialization rate switch.
// Assumes: the divider stage count is chosen by the top-level parameter.
package initclk_pkg;

    // Pacing phase of the switch; it only ever moves from slow to fast.
    typedef enum logic {
        MODE_SLOW = 1'b0,
        MODE_FAST = 1'b1
    } pace_mode_t;

    // Setting codes for div_sel when two stages are built.
    localparam logic SEL_DIV2 = 1'b0;
    localparam logic SEL_DIV4 = 1'b1;

endpackage

// File: rtl/icd_divider.sv
// Module icd_divider
// A chain of STAGES toggle flops. Stage i toggles when every lower stage is 1,
// so the chain counts the fast-clock edges since reset. The divide setting is
// captured while reset is low. tick is high in the last cycle of each divided
// period: divide by 2^(setting+1), and settings above STAGES-1 are clamped.
// Assumes: hold stays high once the fast phase starts, which freezes the chain.
module icd_divider #(
    parameter int STAGES = 2,
    parameter int SEL_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             hold,
    output logic             tick
);

    localparam int TOP_SEL = STAGES - 1;

    logic [SEL_W-1:0]  sel_q;
    logic [STAGES-1:0] stage_q;
    logic [STAGES:0]   carry;
    logic [STAGES-1:0] used_mask;
    logic [SEL_W-1:0]  sel_eff;

    // Capture the divide setting only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= div_sel;
        end
    end

    assign carry[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            logic bit_q;

            // Toggle this stage when all lower stages are set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (!hold && carry[gi]) begin
                    bit_q <= ~bit_q;
                end
            end

            assign stage_q[gi]  = bit_q;
            assign carry[gi+1]  = carry[gi] & bit_q;
        end
    endgenerate

    // Clamp the setting to the number of stages that exist.
    always_comb begin
        if (int'(sel_q) > TOP_SEL) begin
            sel_eff = SEL_W'(TOP_SEL);
        end else begin
            sel_eff = sel_q;
        end
    end

    // Mark which stages take part in the selected ratio.
    always_comb begin
        for (int j = 0; j < STAGES; j++) begin
            used_mask[j] = (j <= int'(sel_eff));
        end
    end

    // Tick when every stage in use is set.
    assign tick = &(stage_q | ~used_mask);

endmodule

// File: rtl/icd_run_reg.sv
// Module icd_run_reg
// Registers the run request into a sticky phase flag. The request takes effect
// one edge after it is sampled, and nothing but reset returns the flag to slow.
// Assumes: run_req is produced in the same clock domain on a rising edge.
module icd_run_reg
    import initclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_req,
    output logic fast
);

    pace_mode_t mode_q;

    // One-way move from slow to fast on a sampled request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SLOW;
        end else if (run_req) begin
            mode_q <= MODE_FAST;
        end
    end

    assign fast = (mode_q == MODE_FAST);

endmodule

// File: rtl/icd_en_mux.sv
// Module icd_en_mux
// Selects the enable source: the divider tick in the slow phase, and a constant
// high in the fast phase.
// Assumes: both inputs come straight from registers, so the select is glitch-safe.
module icd_en_mux (
    input  logic fast,
    input  logic tick,
    output logic clk_en
);

    // Choose the enable source from the registered phase.
    always_comb begin
        if (fast) begin
            clk_en = 1'b1;
        end else begin
            clk_en = tick;
        end
    end

endmodule

// File: rtl/initclk_switch.sv
// Module initclk_switch
// Top of the initialization rate switch. A divided enable paces the cipher core
// during initialization. A registered run request moves the core to an enable
// that is high every cycle.
// Assumes: a single fast clock; div_sel is static outside reset.
module initclk_switch #(
    parameter int STAGES = 2,
    parameter int SEL_W  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             run_req,
    output logic             clk_en
);

    logic fast_q;
    logic div_tick;

    icd_run_reg u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_req (run_req),
        .fast    (fast_q)
    );

    icd_divider #(
        .STAGES (STAGES),
        .SEL_W  (SEL_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .hold    (fast_q),
        .tick    (div_tick)
    );

    icd_en_mux u_mux (
        .fast   (fast_q),
        .tick   (div_tick),
        .clk_en (clk_en)
    );

endmodule

// File: rtl/initclk_switch_chk.sv
// Module initclk_switch_chk
// Checker for the rate switch, attached to the top by the bind below.
// Assumes: fast_q is the registered phase flag inside the top.
module initclk_switch_chk (
    input logic clk,
    input logic rst_n,
    input logic run_req,
    input logic clk_en,
    input logic fast_q
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !clk_en);

    // R5
    switch_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_req |=> clk_en);

    // R6
    fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_q |=> (fast_q && clk_en));

    // R3
    slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_q && clk_en) |=> (!clk_en || fast_q));

endmodule

bind initclk_switch initclk_switch_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_req (run_req),
    .clk_en  (clk_en),
    .fast_q  (fast_q)
);

// File: tb/initclk_switch_tb.sv
`timescale 1ns/1ps
module initclk_switch_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] div_sel = 1'b0;
    logic run_req = 1'b0;
    logic clk_en;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // Reference state: edges since reset release, phase, ratio.
    int  m_edges = 0;
    bit  m_fast = 0;
    int  m_ratio = 2;
    bit  sel_moved = 0;

    always #2.5 clk = ~clk;

    initclk_switch u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .run_req (run_req),
        .clk_en  (clk_en)
    );

    // Behavioural reference updated at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_edges = 0;
            m_fast  = 0;
            m_ratio = (div_sel == 1'b1) ? 4 : 2;   // R2: encoding 0 -> /2, 1 -> /4
        end else begin
            if (!m_fast && run_req) m_fast = 1;
            m_edges++;
        end
    end

    // Compare with the reference away from the active edge.
    always @(negedge clk) begin
        bit exp_en;
        string tag;
        cycles++;
        exp_en = m_fast || ((m_edges % m_ratio) == (m_ratio - 1));
        if (!rst_n)            tag = "R1";
        else if (m_fast)       tag = "R5/R6";
        else if (m_ratio == 2) tag = sel_moved ? "R3 (R2 change ignored)" : "R3";
        else                   tag = sel_moved ? "R4 (R2 change ignored)" : "R4";
        tests++;
        if (clk_en !== exp_en) begin
            fails++;
            $display("FAIL %s: cycle %0d clk_en=%b expected %b", tag, cycles, clk_en, exp_en);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_reset(input logic sel, input int n);
        rst_n = 1'b0;
        div_sel = sel;
        sel_moved = 0;
        wait_cyc(n);
        rst_n = 1'b1;
    endtask

    initial begin
        #1;
        // Divide by 2, run as a single-cycle pulse.
        do_reset(1'b0, 3);                   // R1
        wait_cyc(6);                         // R3
        div_sel = 1'b1; sel_moved = 1;       // R2: must be ignored
        wait_cyc(6);
        run_req = 1'b1;                      // R5
        wait_cyc(1);
        run_req = 1'b0;                      // R6
        wait_cyc(10);

        // Divide by 4, request right after a tick.
        do_reset(1'b1, 2);
        wait_cyc(9);                         // R4
        div_sel = 1'b0; sel_moved = 1;       // R2
        wait_cyc(3);
        run_req = 1'b1;                      // R5
        wait_cyc(3);
        run_req = 1'b0;                      // R6
        wait_cyc(8);

        // Divide by 4, request at mid phase.
        do_reset(1'b1, 2);
        wait_cyc(2);
        run_req = 1'b1;                      // R5
        wait_cyc(1);
        run_req = 1'b0;
        wait_cyc(6);

        // Request already high while reset is held.
        rst_n = 1'b0; div_sel = 1'b1; sel_moved = 0; run_req = 1'b1;
        wait_cyc(3);                         // R1
        rst_n = 1'b1;
        wait_cyc(2);
        run_req = 1'b0;
        wait_cyc(5);                         // R6

        // Divide by 2, long slow run, then reset back to slow.
        do_reset(1'b0, 1);
        wait_cyc(20);                        // R3
        run_req = 1'b1;
        wait_cyc(1);
        run_req = 1'b0;
        wait_cyc(4);
        do_reset(1'b1, 1);                   // R1
        wait_cyc(12);                        // R4
        done = 1;
    end

    // Watchdog and summary.
    initial begin
        while (!done && cycles < 100000) @(negedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        #2;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule